// File: doc/BRIEF.md
# Store buffer with fence ordering

This block sits between the memory port of a simple in-order processor and a single-ported memory bus. Stores to ordinary memory are parked in a small first-in, first-out queue and acknowledged at once, so the processor keeps running while the queue drains to the bus in the background. A load that finds no queued store to its address may use the bus before those older stores. A load that does find one is answered from the queue, using the most recent matching store.

One configurable address window is treated as unbufferable. This is meant for device registers whose side effects must happen in program order. Loads and stores in that window wait until the queue is empty and then go straight to the bus, and the processor waits for the bus to complete them. A fence operation is acknowledged only once nothing issued before it remains in flight. Until then no later access is accepted, which gives software a point where it knows every earlier access has taken effect.

Top module: `store_fence_buffer`

## Requirements
- R1: A store outside the unbufferable window, accepted while the queue has a free slot, gets its response (cpu_rsp_valid) in the cycle after acceptance, without waiting for any bus transfer.
- R2: A load outside the unbufferable window whose address matches no queued store is sent to the bus even while older queued stores are still waiting, and it returns the memory contents.
- R3: A load whose address matches one or more queued stores returns the data of the youngest of them and does not use the bus.
- R4: An access inside the window UB_BASE..UB_LIMIT (inclusive) is never queued. It is accepted only when the queue is empty and no bus transfer is open. Its response comes only after the bus has answered it.
- R5: A fence (op code 2 or 3) is accepted only when every earlier store has been written to memory and every earlier load has returned. It responds in the next cycle, and nothing else is accepted while it waits.
- R6: Queued stores are written to memory in the order they were accepted, so repeated stores to one address leave the latest value in memory.
- R7: The queue holds DEPTH entries. A store that arrives while all DEPTH entries are in use is held (cpu_req_ready low) until an entry drains.
- R8: When a load and a queued store both want the bus, the load wins. After MAX_WINS consecutive load wins with stores waiting, the next grant goes to a queued store.
- R9: On the memory side, a request that is not taken keeps the same address, write flag and data until mem_req_ready is high, and at most one request is open until its mem_rsp_valid.
- R10: Reset empties the queue and clears any pending access or fence. Stores that were queued are discarded and never written to memory.
- R11: Processor op encoding on cpu_req_op: 0 is a load, 1 is a store, 2 and 3 are a fence. Every accepted operation produces exactly one cpu_rsp_valid pulse, and loads carry their data on cpu_rsp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor presents an operation |
| cpu_req_ready | output | 1 | Operation accepted in this cycle when valid is also high |
| cpu_req_op | input | 2 | 0 load, 1 store, 2/3 fence |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse per accepted operation |
| cpu_rsp_rdata | output | DATA_W | Load result |
| mem_req_valid | output | 1 | Bus request pending |
| mem_req_ready | input | 1 | Bus takes the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Bus address |
| mem_req_wdata | output | DATA_W | Bus write data |
| mem_rsp_valid | input | 1 | Bus completes the open request |
| mem_rsp_rdata | input | DATA_W | Bus read data |

## Verification
The bench builds the block with DEPTH 4, a 6-bit address, the unbufferable window at 0x30..0x37 and MAX_WINS lowered to 2. The small address space makes repeated stores to the same address, and loads that hit them, common under random traffic. The low win limit lets a short burst of loads against a full queue run into the anti-starvation bound. A slow-memory mode keeps the first drain open long enough to fill the queue and to make a load overtake, and a hold mode parks every bus request so that the bench can show forwarding and reset discarding with the bus idle.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    localparam logic [1:0] OPC_LOAD  = 2'd0;
    localparam logic [1:0] OPC_STORE = 2'd1;

endpackage

// File: rtl/sbuf_region.sv
module sbuf_region #(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] UB_BASE = 8'hC0,
    parameter logic [ADDR_W-1:0] UB_LIMIT = 8'hCF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window
);
    assign in_window = (addr >= UB_BASE) && (addr <= UB_LIMIT);
endmodule

// File: rtl/sbuf_forward.sv
module sbuf_forward #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
    input  logic [PTR_W-1:0]             oldest,
    input  logic [ADDR_W-1:0]            look_addr,
    output logic                         hit,
    output logic [DATA_W-1:0]            hit_data
);
    logic [PTR_W-1:0] idx;

    // Walk oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        idx      = oldest;
        for (int i = 0; i < DEPTH; i++) begin
            idx = oldest + PTR_W'(i);
            if (ent_vld[idx] && (ent_addr[idx] == look_addr)) begin
                hit      = 1'b1;
                hit_data = ent_data[idx];
            end
        end
    end
endmodule

// File: rtl/store_fence_buffer.sv
module store_fence_buffer
    import sbuf_pkg::*;
#(
    parameter int                DEPTH    = 4,
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 16,
    parameter int                MAX_WINS = 8,
    parameter logic [ADDR_W-1:0] UB_BASE  = 8'hC0,
    parameter logic [ADDR_W-1:0] UB_LIMIT = 8'hCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic [1:0]        cpu_req_op,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int WIN_W = $clog2(MAX_WINS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [WIN_W-1:0] WIN_LIM  = WIN_W'(MAX_WINS);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
        logic [CNT_W-1:0]             cnt;
        phase_e                       phase;
        logic                         p_we;
        logic [ADDR_W-1:0]            p_addr;
        logic [DATA_W-1:0]            p_wdata;
        logic                         busy;
        logic                         busy_cpu;
        logic                         lock;
        logic                         lock_cpu;
        logic [WIN_W-1:0]             wins;
        logic                         rsp_v;
        logic [DATA_W-1:0]            rsp_data;
    } state_t;

    state_t s_q, s_d;

    logic              cpu_in_ub, bus_in_ub;
    logic              fwd_hit;
    logic [DATA_W-1:0] fwd_data;
    logic              is_load, is_store, is_fence, idle, drained, accept;
    logic              cpu_want, drain_want, pick_cpu, push, pop;

    sbuf_region #(.ADDR_W(ADDR_W), .UB_BASE(UB_BASE), .UB_LIMIT(UB_LIMIT)) u_cpu_region (
        .addr(cpu_req_addr), .in_window(cpu_in_ub));

    sbuf_region #(.ADDR_W(ADDR_W), .UB_BASE(UB_BASE), .UB_LIMIT(UB_LIMIT)) u_bus_region (
        .addr(mem_req_addr), .in_window(bus_in_ub));

    sbuf_forward #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_forward (
        .ent_vld(s_q.vld), .ent_addr(s_q.addr), .ent_data(s_q.data),
        .oldest(s_q.head), .look_addr(cpu_req_addr),
        .hit(fwd_hit), .hit_data(fwd_data));

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;

        is_load  = (cpu_req_op == OPC_LOAD);
        is_store = (cpu_req_op == OPC_STORE);
        is_fence = cpu_req_op[1];
        idle     = (s_q.phase == PH_IDLE);
        drained  = (s_q.cnt == '0) && !s_q.busy;

        // Processor side acceptance
        if (!idle)                   cpu_req_ready = 1'b0;
        else if (is_fence)           cpu_req_ready = drained;
        else if (cpu_in_ub)          cpu_req_ready = drained;
        else if (is_store)           cpu_req_ready = (s_q.cnt < CNT_FULL);
        else                         cpu_req_ready = 1'b1;
        accept = cpu_req_valid && cpu_req_ready;

        if (accept) begin
            if (is_fence) begin
                s_d.rsp_v    = 1'b1;
                s_d.rsp_data = '0;
            end else if (cpu_in_ub || (is_load && !fwd_hit)) begin
                s_d.phase   = PH_ISSUE;
                s_d.p_we    = is_store;
                s_d.p_addr  = cpu_req_addr;
                s_d.p_wdata = cpu_req_wdata;
            end else if (is_store) begin
                push                 = 1'b1;
                s_d.vld[s_q.tail]    = 1'b1;
                s_d.addr[s_q.tail]   = cpu_req_addr;
                s_d.data[s_q.tail]   = cpu_req_wdata;
                s_d.tail             = s_q.tail + 1'b1;
                s_d.rsp_v            = 1'b1;
                s_d.rsp_data         = '0;
            end else begin
                s_d.rsp_v    = 1'b1;
                s_d.rsp_data = fwd_data;
            end
        end

        // Bus arbitration: loads first, bounded by the win counter
        cpu_want   = (s_q.phase == PH_ISSUE);
        drain_want = (s_q.cnt != '0);
        if (s_q.lock) pick_cpu = s_q.lock_cpu;
        else          pick_cpu = cpu_want && (!drain_want || (s_q.wins < WIN_LIM));

        mem_req_valid = !s_q.busy && (cpu_want || drain_want);
        mem_req_we    = pick_cpu ? s_q.p_we    : 1'b1;
        mem_req_addr  = pick_cpu ? s_q.p_addr  : s_q.addr[s_q.head];
        mem_req_wdata = pick_cpu ? s_q.p_wdata : s_q.data[s_q.head];

        s_d.lock     = mem_req_valid && !mem_req_ready;
        s_d.lock_cpu = pick_cpu;

        if (mem_req_valid && mem_req_ready) begin
            s_d.busy     = 1'b1;
            s_d.busy_cpu = pick_cpu;
            if (pick_cpu) begin
                s_d.phase = PH_WAIT;
                if (drain_want) s_d.wins = s_q.wins + 1'b1;
            end else begin
                s_d.wins = '0;
            end
        end

        // Bus completion
        if (mem_rsp_valid && s_q.busy) begin
            s_d.busy = 1'b0;
            if (s_q.busy_cpu) begin
                s_d.phase    = PH_IDLE;
                s_d.rsp_v    = 1'b1;
                s_d.rsp_data = mem_rsp_rdata;
            end else begin
                pop               = 1'b1;
                s_d.vld[s_q.head] = 1'b0;
                s_d.head          = s_q.head + 1'b1;
            end
        end

        s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cpu_rsp_valid = s_q.rsp_v;
    assign cpu_rsp_rdata = s_q.rsp_data;

    // Checks beside the logic they guard
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_FULL) else $error("queue overflow"); // R7
    AST_STORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_store && !cpu_in_ub) |=> cpu_rsp_valid) else $error("store ack late"); // R1
    AST_FENCE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_fence) |-> (s_q.cnt == '0 && !s_q.busy)) else $error("fence early"); // R5
    AST_UB_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && bus_in_ub) |-> (s_q.cnt == '0)) else $error("ub with queue"); // R4
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wins <= WIN_LIM) else $error("starvation bound"); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we))) else $error("req dropped"); // R9
    AST_RSP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> s_q.busy) else $error("stray response"); // R9
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (s_q.cnt == '0 && !cpu_rsp_valid)) else $error("reset left state"); // R10

endmodule

// File: tb/tb_store_fence_buffer.sv
module tb_store_fence_buffer;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int MAXW = 2;
    localparam logic [AW-1:0] UBB = 6'h30;
    localparam logic [AW-1:0] UBL = 6'h37;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 1'b0;
    logic cpu_req_ready;
    logic [1:0] cpu_req_op = 2'd0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_rdata;
    logic mem_req_valid, mem_req_we;
    logic mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;

    always #4 clk = ~clk;

    store_fence_buffer #(.DEPTH(4), .ADDR_W(AW), .DATA_W(DW), .MAX_WINS(MAXW),
        .UB_BASE(UBB), .UB_LIMIT(UBL)) dut (.*);

    // Memory model
    logic [DW-1:0] mem [64];
    logic [DW-1:0] refm [64];
    logic pend = 1'b0, rdy_rand = 1'b0, hold_all = 1'b0, slow = 1'b0;
    int lat = 0;
    assign mem_req_ready = rdy_rand && !pend && !hold_all;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        rdy_rand <= ($urandom % 4) != 0;
        if (pend) begin
            if (lat == 0) begin mem_rsp_valid <= 1'b1; pend <= 1'b0; end
            else lat <= lat - 1;
        end
        if (mem_req_valid && mem_req_ready) begin
            pend <= 1'b1;
            lat <= slow ? 20 : int'($urandom % 3);
            mem_rsp_rdata <= mem[mem_req_addr];
            if (mem_req_we) mem[mem_req_addr] <= mem_req_wdata;
        end
    end

    int checks = 0, errors = 0, mon_checks = 0, mon_errs = 0;
    int stores_acc = 0, writes_done = 0, consec = 0, bypass = 0;
    logic prev_stall = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic prev_we = 1'b0;

    function automatic logic in_ub(input logic [AW-1:0] a);
        return (a >= UBB) && (a <= UBL);
    endfunction

    // Bus monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            prev_stall = 1'b0;
            consec = 0;
        end else begin
            if (prev_stall) begin
                mon_checks++;
                if (!mem_req_valid || mem_req_addr != prev_addr || mem_req_we != prev_we) begin
                    mon_errs++;
                    $display("FAIL R9 request changed: valid=%0b addr=%0h expected addr=%0h", mem_req_valid, mem_req_addr, prev_addr);
                end
            end
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
            prev_we    = mem_req_we;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    if (in_ub(mem_req_addr)) begin
                        mon_checks++;
                        if (writes_done != stores_acc - 1) begin
                            mon_errs++;
                            $display("FAIL R4 ub write before drain: writes=%0d expected %0d", writes_done, stores_acc - 1);
                        end
                    end
                    writes_done++;
                    consec = 0;
                end else if (stores_acc > writes_done) begin
                    consec++;
                    bypass++;
                    mon_checks++;
                    if (consec > MAXW) begin
                        mon_errs++;
                        $display("FAIL R8 load wins=%0d expected <= %0d", consec, MAXW);
                    end
                end else begin
                    consec = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] r);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_op = op; cpu_req_addr = a; cpu_req_wdata = d;
        #1;
        while (!cpu_req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        if (op == 2'd1) begin stores_acc++; refm[a] = d; end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!cpu_rsp_valid) @(negedge clk);
        r = cpu_rsp_rdata;
    endtask

    task automatic load_chk(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] r;
        do_op(2'd0, a, '0, r);
        chk(r == refm[a], req, r, refm[a]);
    endtask

    task automatic fence_chk(input string req);
        logic [DW-1:0] r;
        do_op(2'd2, '0, '0, r);
        chk(writes_done == stores_acc, req, writes_done, stores_acc);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] r;
        logic [DW-1:0] old5, old6;
        int w0;
        void'($urandom(32'd7));
        for (int i = 0; i < 64; i++) begin mem[i] = DW'(i * 3 + 7); refm[i] = DW'(i * 3 + 7); end
        repeat (3) @(negedge clk);
        chk(!mem_req_valid && !cpu_rsp_valid, "R10 reset outputs", mem_req_valid, 0);
        chk(cpu_req_ready, "R10 idle ready", cpu_req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3: bus parked, stores acked and forwarded
        hold_all = 1'b1;
        w0 = writes_done;
        do_op(2'd1, 6'h04, 16'h1111, r);
        chk(writes_done == w0, "R1 store acked without bus", writes_done, w0);
        do_op(2'd1, 6'h04, 16'h2222, r);
        do_op(2'd0, 6'h04, '0, r);
        chk(r == 16'h2222, "R3 youngest forwarded", r, 16'h2222);
        chk(writes_done == w0, "R3 no bus used", writes_done, w0);
        hold_all = 1'b0;
        fence_chk("R5 fence after drain");
        chk(mem[4] == 16'h2222, "R6 fifo order same address", mem[4], 16'h2222);

        // R2 / R7: slow memory keeps the first drain open
        slow = 1'b1;
        do_op(2'd1, 6'h08, 16'hA001, r);
        do_op(2'd1, 6'h09, 16'hA002, r);
        do_op(2'd1, 6'h0A, 16'hA003, r);
        do_op(2'd1, 6'h0B, 16'hA004, r);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_op = 2'd1; cpu_req_addr = 6'h0C; cpu_req_wdata = 16'hA005;
        #1;
        chk(!cpu_req_ready, "R7 full store stalls", cpu_req_ready, 0);
        repeat (4) @(negedge clk);
        #1;
        chk(!cpu_req_ready, "R7 still stalled", cpu_req_ready, 0);
        cpu_req_valid = 1'b0;
        do_op(2'd1, 6'h0C, 16'hA005, r);
        load_chk(6'h10, "R2 load value while stores queued");
        chk(writes_done < stores_acc, "R2 load overtook stores", writes_done, stores_acc);
        slow = 1'b0;
        fence_chk("R5 fence after overtake");

        // R8: load burst against a full queue
        hold_all = 1'b1;
        for (int i = 0; i < 4; i++) do_op(2'd1, 6'(20 + i), DW'(16'hB000 + i), r);
        hold_all = 1'b0;
        for (int i = 0; i < 8; i++) load_chk(6'(i), "R8 loads during drain");
        fence_chk("R8 drain completed");

        // R4: unbufferable store and load behind queued stores
        do_op(2'd1, 6'h01, 16'hC001, r);
        do_op(2'd1, 6'h02, 16'hC002, r);
        do_op(2'd1, 6'h31, 16'hD00D, r);
        chk(mem[6'h31] == 16'hD00D, "R4 ub store complete at response", mem[6'h31], 16'hD00D);
        chk(writes_done == stores_acc, "R4 ub after drain", writes_done, stores_acc);
        load_chk(6'h31, "R4 ub load");

        // R10: reset discards queued stores
        hold_all = 1'b1;
        old5 = refm[5]; old6 = refm[6];
        do_op(2'd1, 6'h05, 16'hEEE5, r);
        do_op(2'd1, 6'h06, 16'hEEE6, r);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        refm[5] = old5; refm[6] = old6; stores_acc = stores_acc - 2;
        w0 = writes_done;
        hold_all = 1'b0;
        repeat (30) @(negedge clk);
        chk(writes_done == w0, "R10 no write after reset", writes_done, w0);
        chk(mem[5] == old5, "R10 memory untouched", mem[5], old5);
        load_chk(6'h06, "R10 load after reset");

        // Random traffic (R2 R3 R5 R6 R11)
        for (int n = 0; n < 800; n++) begin
            int k;
            logic [AW-1:0] a;
            k = int'($urandom % 16);
            a = (k >= 14) ? 6'(UBB + ($urandom % 8)) : 6'($urandom % 12);
            if (k < 6 || k == 14) do_op(2'd1, a, DW'($urandom), r);
            else if (k < 12 || k == 15) begin
                do_op(2'd0, a, '0, r);
                chk(r == refm[a], "R11 random load", r, refm[a]);
            end else fence_chk("R5 random fence");
        end
        fence_chk("R5 final fence");
        for (int i = 0; i < 64; i++)
            chk(mem[i] == refm[i], "R6 final memory", mem[i], refm[i]);
        chk(bypass > 0, "R2 bypass observed", bypass, 1);
        finish_run();
    end
endmodule